// File: doc/BRIEF.md
# Debug Run Controller for a Gated User Clock

This block runs in a fast, always-on control clock domain. It drives a clock-enable that gates a much slower user design, and gives debugger-style run control over it. A host issues commands to run freely, halt, execute one user cycle, or execute a burst of N user cycles. The controller keeps a count of the user cycles that have executed.

Execution also stops by itself when one of several events occurs:

- a cycle-count breakpoint is reached;
- a masked comparison on a monitored design value matches;
- any assertion monitor reports a failure.

Each stop leaves the controller halted, and a reason code tells the host why. Capture units that are close to overflowing their storage can raise a stall request. A stall holds the user clock for as long as the request stays high, and the controller does not leave its current run state.

A user cycle is one control-clock cycle in which `user_cke` is high. Any halt cause seen in a cycle is registered at the next edge. So the cycle that triggers a stop always completes, and the stop takes effect from the following cycle.

Top module: `dbg_run_ctrl`

## Requirements
- R1: After reset the controller is halted, `user_cke` is low, `cycle_count` is 0 and `halt_reason` is 0 (none).
- R2: Host opcodes are 1 halt, 2 run, 3 step and 4 burst; 0 and 5 to 7 have no effect. Run, step and burst are accepted only while halted. A halt while not halted stops at the next edge with reason 1. A halt while already halted changes nothing.
- R3: `user_cke` is high in every non-halted cycle without a stall. `cycle_count` grows by exactly one at the end of each cycle with `user_cke` high, and holds otherwise.
- R4: A step executes exactly one user cycle and then halts with reason 2.
- R5: A burst of N (N taken from `cmd_arg`) executes exactly N user cycles and then halts with reason 2. A burst with N = 0 is ignored.
- R6: With the cycle breakpoint enabled, a user cycle that brings `cycle_count` to `bp_cyc_value` is the last one executed, and the halt reason is 3.
- R7: With the state breakpoint enabled, a user cycle in which `(mon_value & bp_st_mask) == (bp_st_pattern & bp_st_mask)` is the last one executed, and the halt reason is 4. Masked-out bits never prevent a match.
- R8: Any bit of `assert_fail` that is high while not halted stops execution at the next edge with reason 5.
- R9: Any bit of `stall_req` holds `user_cke` low in that same cycle. The run state stays as it is, and execution resumes when the request clears. Stalled cycles do not count toward a step or a burst.
- R10: When several halt causes occur in one cycle, the reported reason follows this order: assertion (5), state breakpoint (4), cycle breakpoint (3), step/burst completion (2), host halt (1).
- R11: `run_state` encodes 0 halted, 1 running, 2 stepping, 3 burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command strobe, one cycle per command |
| cmd_op | input | 3 | Host opcode |
| cmd_arg | input | BURST_W | Burst length for opcode 4 |
| bp_cyc_en | input | 1 | Enables the cycle-count breakpoint |
| bp_cyc_value | input | CNT_W | Cycle count at which to stop |
| bp_st_en | input | 1 | Enables the state breakpoint |
| bp_st_mask | input | MON_W | Bits of the monitored value taking part in the compare |
| bp_st_pattern | input | MON_W | Pattern for the state breakpoint |
| mon_value | input | MON_W | Monitored user-design state |
| assert_fail | input | N_ASRT | Failure flags from assertion monitors |
| stall_req | input | N_STALL | Stall requests from capture units |
| user_cke | output | 1 | Clock enable for the user design |
| run_state | output | 2 | Current run state |
| halt_reason | output | 3 | Cause of the latest halt |
| cycle_count | output | CNT_W | Number of executed user cycles |

## Verification
The bench builds the block with a 16-bit cycle counter, 8-bit burst lengths, an 8-bit monitored value, two assertion inputs and three stall inputs. These narrow widths keep cycle breakpoint targets and burst lengths small, so each stop can be counted exactly within a few dozen cycles. The 8-bit monitor lets a single mask value show that masked-out bits are ignored. With two or three request lines, the bench can show that a line other than bit 0 also reaches the OR-merge.

// File: rtl/dbg_run_pkg.sv
package dbg_run_pkg;

    typedef enum logic [1:0] {
        RS_HALTED   = 2'd0,
        RS_RUNNING  = 2'd1,
        RS_STEPPING = 2'd2,
        RS_BURST    = 2'd3
    } run_state_e;

    typedef enum logic [2:0] {
        HR_NONE   = 3'd0,
        HR_HOST   = 3'd1,
        HR_DONE   = 3'd2,
        HR_CYCLE  = 3'd3,
        HR_STATE  = 3'd4,
        HR_ASSERT = 3'd5
    } halt_rsn_e;

    localparam logic [2:0] OP_NOP   = 3'd0;
    localparam logic [2:0] OP_HALT  = 3'd1;
    localparam logic [2:0] OP_RUN   = 3'd2;
    localparam logic [2:0] OP_STEP  = 3'd3;
    localparam logic [2:0] OP_BURST = 3'd4;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_run_pkg::*;
#(
    parameter int BURST_W = 16
) (
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [BURST_W-1:0] cmd_arg,
    output logic               req_halt,
    output logic               req_run,
    output logic               req_step,
    output logic               req_burst
);

    logic arg_nonzero;

    always_comb begin
        arg_nonzero = |cmd_arg;
        req_halt    = cmd_valid && (cmd_op == OP_HALT);
        req_run     = cmd_valid && (cmd_op == OP_RUN);
        req_step    = cmd_valid && (cmd_op == OP_STEP);
        // a zero-length burst is dropped here so the FSM never sees it
        req_burst   = cmd_valid && (cmd_op == OP_BURST) && arg_nonzero;
    end

endmodule

// File: rtl/dbg_event_merge.sv
module dbg_event_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] evt,
    output logic         any
);

    generate
        if (N == 1) begin : g_single
            assign any = evt[0];
        end else begin : g_reduce
            assign any = |evt;
        end
    endgenerate

endmodule

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit #(
    parameter int CNT_W = 32,
    parameter int MON_W = 16
) (
    input  logic             cke,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cyc_en,
    input  logic [CNT_W-1:0] cyc_val,
    input  logic             st_en,
    input  logic [MON_W-1:0] st_mask,
    input  logic [MON_W-1:0] st_pat,
    input  logic [MON_W-1:0] mon,
    output logic             cyc_hit,
    output logic             st_hit
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [MON_W-1:0] bit_ok;
    logic [CNT_W-1:0] cnt_after;

    // per-bit compare: a masked-out bit always agrees
    generate
        for (genvar b = 0; b < MON_W; b++) begin : g_bit
            assign bit_ok[b] = !st_mask[b] || (mon[b] == st_pat[b]);
        end
    endgenerate

    always_comb begin
        cnt_after = cnt + CNT_ONE;
        cyc_hit   = cyc_en && cke && (cnt_after == cyc_val);
        st_hit    = st_en && cke && (&bit_ok);
    end

endmodule

// File: rtl/dbg_cycle_ctr.sv
module dbg_cycle_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cke) begin
            cnt_d = cnt_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
    import dbg_run_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BURST_W = 16,
    parameter int MON_W   = 16,
    parameter int N_ASRT  = 4,
    parameter int N_STALL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [BURST_W-1:0] cmd_arg,
    input  logic               bp_cyc_en,
    input  logic [CNT_W-1:0]   bp_cyc_value,
    input  logic               bp_st_en,
    input  logic [MON_W-1:0]   bp_st_mask,
    input  logic [MON_W-1:0]   bp_st_pattern,
    input  logic [MON_W-1:0]   mon_value,
    input  logic [N_ASRT-1:0]  assert_fail,
    input  logic [N_STALL-1:0] stall_req,
    output logic               user_cke,
    output logic [1:0]         run_state,
    output logic [2:0]         halt_reason,
    output logic [CNT_W-1:0]   cycle_count
);

    localparam logic [BURST_W-1:0] LEFT_ONE = {{(BURST_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        run_state_e         st;
        halt_rsn_e          rsn;
        logic [BURST_W-1:0] left;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic req_halt, req_run, req_step, req_burst;
    logic asrt_any, stall_any;
    logic cyc_hit, st_hit;
    logic cke;
    logic [CNT_W-1:0] cnt;

    dbg_cmd_decode #(.BURST_W(BURST_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .req_halt  (req_halt),
        .req_run   (req_run),
        .req_step  (req_step),
        .req_burst (req_burst)
    );

    dbg_event_merge #(.N(N_ASRT)) u_asrt_merge (
        .evt (assert_fail),
        .any (asrt_any)
    );

    dbg_event_merge #(.N(N_STALL)) u_stall_merge (
        .evt (stall_req),
        .any (stall_any)
    );

    assign cke = (ctl_q.st != RS_HALTED) && !stall_any;

    dbg_bp_unit #(.CNT_W(CNT_W), .MON_W(MON_W)) u_bp (
        .cke     (cke),
        .cnt     (cnt),
        .cyc_en  (bp_cyc_en),
        .cyc_val (bp_cyc_value),
        .st_en   (bp_st_en),
        .st_mask (bp_st_mask),
        .st_pat  (bp_st_pattern),
        .mon     (mon_value),
        .cyc_hit (cyc_hit),
        .st_hit  (st_hit)
    );

    dbg_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .cke   (cke),
        .cnt   (cnt)
    );

    // next-state: later halt causes override earlier ones (priority)
    always_comb begin
        logic      stop;
        halt_rsn_e why;
        logic      counted;

        ctl_d   = ctl_q;
        stop    = 1'b0;
        why     = ctl_q.rsn;
        counted = (ctl_q.st == RS_STEPPING) || (ctl_q.st == RS_BURST);

        if (ctl_q.st == RS_HALTED) begin
            if (req_run) begin
                ctl_d.st = RS_RUNNING;
            end else if (req_step) begin
                ctl_d.st   = RS_STEPPING;
                ctl_d.left = LEFT_ONE;
            end else if (req_burst) begin
                ctl_d.st   = RS_BURST;
                ctl_d.left = cmd_arg;
            end
        end else begin
            if (req_halt) begin
                stop = 1'b1;
                why  = HR_HOST;
            end
            if (counted && cke && (ctl_q.left == LEFT_ONE)) begin
                stop = 1'b1;
                why  = HR_DONE;
            end
            if (cyc_hit) begin
                stop = 1'b1;
                why  = HR_CYCLE;
            end
            if (st_hit) begin
                stop = 1'b1;
                why  = HR_STATE;
            end
            if (asrt_any) begin
                stop = 1'b1;
                why  = HR_ASSERT;
            end
            if (counted && cke) begin
                ctl_d.left = ctl_q.left - LEFT_ONE;
            end
            if (stop) begin
                ctl_d.st   = RS_HALTED;
                ctl_d.rsn  = why;
                ctl_d.left = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: RS_HALTED, rsn: HR_NONE, left: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign user_cke    = cke;
    assign run_state   = ctl_q.st;
    assign halt_reason = ctl_q.rsn;
    assign cycle_count = cnt;

    AST_HALT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != RS_HALTED) |=> (ctl_q.st != RS_HALTED || ctl_q.rsn != HR_NONE)); // R2
    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == RS_STEPPING && user_cke) |=> (ctl_q.st == RS_HALTED)); // R4
    AST_ZERO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == RS_HALTED && cmd_valid && cmd_op == OP_BURST && cmd_arg == '0)
            |=> (ctl_q.st == RS_HALTED)); // R5
    AST_ASSERT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != RS_HALTED && |assert_fail)
            |=> (ctl_q.st == RS_HALTED && ctl_q.rsn == HR_ASSERT)); // R8
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != RS_HALTED && |stall_req && !(|assert_fail)
            && !(cmd_valid && cmd_op == OP_HALT))
            |=> ($stable(ctl_q.st) && $stable(ctl_q.left))); // R9
    AST_STALL_NO_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        (|stall_req) |-> !user_cke); // R9

endmodule

// File: tb/dbg_run_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_run_ctrl_tb;

    localparam int CW = 16;
    localparam int BW = 8;
    localparam int MW = 8;
    localparam int NA = 2;
    localparam int NS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [BW-1:0] cmd_arg = '0;
    logic          bp_cyc_en = 1'b0;
    logic [CW-1:0] bp_cyc_value = '0;
    logic          bp_st_en = 1'b0;
    logic [MW-1:0] bp_st_mask = '0;
    logic [MW-1:0] bp_st_pattern = '0;
    logic [MW-1:0] mon_value = '0;
    logic [NA-1:0] assert_fail = '0;
    logic [NS-1:0] stall_req = '0;
    logic          user_cke;
    logic [1:0]    run_state;
    logic [2:0]    halt_reason;
    logic [CW-1:0] cycle_count;

    always #2.5 clk = ~clk;

    dbg_run_ctrl #(
        .CNT_W(CW), .BURST_W(BW), .MON_W(MW), .N_ASRT(NA), .N_STALL(NS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .bp_cyc_en(bp_cyc_en), .bp_cyc_value(bp_cyc_value),
        .bp_st_en(bp_st_en), .bp_st_mask(bp_st_mask), .bp_st_pattern(bp_st_pattern),
        .mon_value(mon_value), .assert_fail(assert_fail), .stall_req(stall_req),
        .user_cke(user_cke), .run_state(run_state), .halt_reason(halt_reason),
        .cycle_count(cycle_count)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic host(input logic [2:0] op, input logic [BW-1:0] arg);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = arg;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        cmd_op    = '0;
        cmd_arg   = '0;
    endtask

    // {op[3], arg[8], wait[8], exp_count[16], exp_state[2], exp_reason[3]}
    localparam int NV = 12;
    localparam logic [39:0] VEC [NV] = '{
        {3'd3, 8'd0, 8'd3,  16'd1,  2'd0, 3'd2},  // step
        {3'd4, 8'd5, 8'd8,  16'd6,  2'd0, 3'd2},  // burst 5
        {3'd4, 8'd0, 8'd3,  16'd6,  2'd0, 3'd2},  // burst 0 ignored
        {3'd2, 8'd0, 8'd10, 16'd16, 2'd1, 3'd2},  // run
        {3'd2, 8'd0, 8'd2,  16'd19, 2'd1, 3'd2},  // run while running ignored
        {3'd1, 8'd0, 8'd2,  16'd20, 2'd0, 3'd1},  // host halt
        {3'd1, 8'd0, 8'd2,  16'd20, 2'd0, 3'd1},  // halt while halted ignored
        {3'd3, 8'd0, 8'd2,  16'd21, 2'd0, 3'd2},  // step
        {3'd0, 8'd0, 8'd2,  16'd21, 2'd0, 3'd2},  // nop
        {3'd4, 8'd3, 8'd5,  16'd24, 2'd0, 3'd2},  // burst 3
        {3'd4, 8'd1, 8'd1,  16'd25, 2'd0, 3'd2},  // burst 1
        {3'd7, 8'd9, 8'd3,  16'd25, 2'd0, 3'd2}   // undefined opcode
    };
    string vtag [NV] = '{"R4", "R5", "R5", "R3", "R2", "R2",
                         "R2", "R4", "R2", "R5", "R5", "R2"};

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c;
        edges(3);
        chk("R1", "state", int'(run_state), 0);
        chk("R1", "count", int'(cycle_count), 0);
        chk("R1", "reason", int'(halt_reason), 0);
        chk("R1", "cke", int'(user_cke), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            host(VEC[i][39:37], VEC[i][36:29]);
            edges(int'(VEC[i][28:21]));
            chk(vtag[i], $sformatf("vec%0d count", i), int'(cycle_count), int'(VEC[i][20:5]));
            chk("R11", $sformatf("vec%0d state", i), int'(run_state), int'(VEC[i][4:3]));
            chk(vtag[i], $sformatf("vec%0d reason", i), int'(halt_reason), int'(VEC[i][2:0]));
        end

        // R6 cycle breakpoint at 40, starting from 25
        bp_cyc_value = 16'd40;
        bp_cyc_en    = 1'b1;
        host(3'd2, '0);
        edges(30);
        chk("R6", "count", int'(cycle_count), 40);
        chk("R6", "state", int'(run_state), 0);
        chk("R6", "reason", int'(halt_reason), 3);
        bp_cyc_en = 1'b0;

        // R7 masked state breakpoint
        bp_st_mask    = 8'hF0;
        bp_st_pattern = 8'hA5;
        mon_value     = 8'h00;
        bp_st_en      = 1'b1;
        host(3'd2, '0);
        edges(4);
        chk("R7", "no match keeps running", int'(run_state), 1);
        c = int'(cycle_count);
        mon_value = 8'hAC;
        edges(1);
        chk("R7", "count", int'(cycle_count), c + 1);
        chk("R7", "reason", int'(halt_reason), 4);
        mon_value = 8'h00;
        edges(3);
        chk("R7", "count held", int'(cycle_count), c + 1);

        // R8 assertion on bit 1
        host(3'd2, '0);
        edges(3);
        c = int'(cycle_count);
        assert_fail = 2'b10;
        edges(1);
        assert_fail = '0;
        chk("R8", "count", int'(cycle_count), c + 1);
        chk("R8", "reason", int'(halt_reason), 5);

        // R10 assertion beats state breakpoint
        host(3'd2, '0);
        edges(2);
        c = int'(cycle_count);
        mon_value   = 8'hA5;
        assert_fail = 2'b01;
        edges(1);
        mon_value   = 8'h00;
        assert_fail = '0;
        chk("R10", "assert over state", int'(halt_reason), 5);
        chk("R10", "count", int'(cycle_count), c + 1);

        // R10 state breakpoint beats cycle breakpoint
        host(3'd2, '0);
        edges(2);
        c = int'(cycle_count);
        bp_cyc_value = 16'(c + 1);
        bp_cyc_en    = 1'b1;
        mon_value    = 8'hA5;
        edges(1);
        mon_value = 8'h00;
        bp_cyc_en = 1'b0;
        chk("R10", "state over cycle", int'(halt_reason), 4);
        bp_st_en = 1'b0;

        // R9 stall while running
        host(3'd2, '0);
        edges(2);
        chk("R3", "cke while running", int'(user_cke), 1);
        c = int'(cycle_count);
        stall_req = 3'b100;
        edges(4);
        chk("R9", "count frozen", int'(cycle_count), c);
        chk("R9", "still running", int'(run_state), 1);
        chk("R9", "cke low", int'(user_cke), 0);
        stall_req = '0;
        edges(3);
        chk("R9", "resumed", int'(cycle_count), c + 3);
        host(3'd1, '0);
        chk("R2", "halt count", int'(cycle_count), c + 4);
        chk("R2", "halt reason", int'(halt_reason), 1);

        // R9 stall does not consume burst cycles
        c = int'(cycle_count);
        stall_req = 3'b001;
        host(3'd4, 8'd4);
        edges(3);
        chk("R9", "burst stalled count", int'(cycle_count), c);
        chk("R11", "burst state", int'(run_state), 3);
        stall_req = '0;
        edges(6);
        chk("R5", "burst after stall", int'(cycle_count), c + 4);
        chk("R5", "burst reason", int'(halt_reason), 2);

        // R1 reset during run
        host(3'd2, '0);
        edges(3);
        rst_n = 1'b0;
        edges(1);
        chk("R1", "state after reset", int'(run_state), 0);
        chk("R1", "count after reset", int'(cycle_count), 0);
        chk("R1", "reason after reset", int'(halt_reason), 0);
        rst_n = 1'b1;
        edges(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule